// File: doc/BRIEF.md
# Region-Based Wait State Generator

This block stretches external bus accesses for slow memories and memory-mapped peripherals. When the processor side raises a request, it picks a 3-bit wait code from a 16-bit control word. For an I/O-space access, the code comes from the address region. For a data-memory access, it comes from a dedicated field. A global mode bit then turns the code into a number of wait cycles. The block holds its ready output low for that many cycles and then gives a one-cycle completion pulse.

The I/O space is 2048 words and uses only the low 11 address bits. Bits 10:9 split it into four regions of 512 words, and each region has its own code. The control word is written through a simple write strobe with an address. It is visible at all times on a read-back output. At reset every bit of it is 1, so every access starts out with the longest stretch.

Top module: `wait_state_gen`

## Requirements
- R1: After reset the control word reads 0xFFFF, `xfer_ready` is 1 and `xfer_done` is 0.
- R2: A write with `cfg_wr_en` high and `cfg_addr` equal to 0x3FFE loads `cfg_wdata` into the control word by the next cycle. Writes to any other address leave it unchanged.
- R3: Control word layout: bit 15 is the mode bit and bits 14:12 are the data-memory code. Bits 11:9, 8:6, 5:3 and 2:0 are the codes of I/O regions 3, 2, 1 and 0.
- R4: An I/O access (`req_space` = 0) selects the region from address bits 10:9. Address bits 13:11 have no effect on the wait count.
- R5: With the mode bit at 0, an access with code N inserts N wait cycles (0 to 7).
- R6: With the mode bit at 1, a nonzero code N inserts 2N+1 wait cycles (up to 15), and code 0 inserts none.
- R7: A data-memory access (`req_space` = 1) uses the bits 14:12 code under the same mode bit, whatever its address.
- R8: A request is accepted on a clock edge where `xfer_ready` is 1. For N waits, `xfer_ready` is 0 for the next N cycles. Then `xfer_done` is 1 for exactly one cycle with `xfer_ready` at 1. With N = 0, `xfer_done` rises in the cycle right after the request.
- R9: While `xfer_ready` is 0, new requests are ignored. The wait count in progress is fixed at acceptance and is not changed by a control-word write made during it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr_en | input | 1 | Control-word write strobe |
| cfg_addr | input | 14 | Data-memory address of the write |
| cfg_wdata | input | 16 | Write data |
| cfg_value | output | 16 | Current control word |
| req_valid | input | 1 | Access request |
| req_space | input | 1 | 0 = I/O space, 1 = data memory |
| req_addr | input | 14 | Access address |
| xfer_ready | output | 1 | Low while wait cycles are being inserted |
| xfer_done | output | 1 | One-cycle pulse when the access completes |

## Verification
The bench looks for four kinds of error.

- **Mode-1 encoding of code 0.** A design that computes 2N+1 without special-casing code 0 gives one wait instead of none.
- **Region decode.** If the decode uses the wrong address bits or includes the upper bits, an address with bits 13:11 set gets another region's count.
- **Off-by-one timing.** A design that ends the stretch one cycle early or late shows the wrong number of low-ready cycles, or misses the zero-wait completion in the next cycle.
- **Ignored inputs while busy.** The bench sends a request and then a control-word write in the middle of a stretch. A design that restarts or reloads its counter then gives a longer access or a spurious second completion.

// File: rtl/wsg_pkg.sv
package wsg_pkg;
    localparam int unsigned WSG_ADDR_W    = 14;
    localparam int unsigned WSG_DATA_W    = 16;
    localparam int unsigned WSG_CODE_W    = 3;
    localparam int unsigned WSG_REGIONS   = 4;
    localparam int unsigned WSG_IO_ADDR_W = 11;
    localparam logic [WSG_ADDR_W-1:0] WSG_CTRL_ADDR = 14'h3FFE;

    typedef enum logic {
        SPACE_IO = 1'b0,
        SPACE_DM = 1'b1
    } space_e;
endpackage

// File: rtl/wsg_ctrl_reg.sv
module wsg_ctrl_reg #(
    parameter int unsigned ADDR_W = wsg_pkg::WSG_ADDR_W,
    parameter int unsigned DATA_W = wsg_pkg::WSG_DATA_W,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = wsg_pkg::WSG_CTRL_ADDR
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] value
);
    typedef struct packed {
        logic [DATA_W-1:0] word;
    } reg_state_t;

    reg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en && (wr_addr == CTRL_ADDR)) begin
            st_d.word = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.word <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign value = st_q.word;
endmodule

// File: rtl/wsg_region_decode.sv
module wsg_region_decode #(
    parameter int unsigned DATA_W    = wsg_pkg::WSG_DATA_W,
    parameter int unsigned CODE_W    = wsg_pkg::WSG_CODE_W,
    parameter int unsigned REGIONS   = wsg_pkg::WSG_REGIONS,
    parameter int unsigned IO_ADDR_W = wsg_pkg::WSG_IO_ADDR_W
) (
    input  logic [IO_ADDR_W-1:0] io_addr,
    input  logic                 space,
    input  logic [DATA_W-1:0]    ctrl,
    output logic [CODE_W-1:0]    code,
    output logic                 mode
);
    localparam int unsigned SEL_W  = $clog2(REGIONS);
    localparam int unsigned DM_LSB = REGIONS * CODE_W;
    localparam int unsigned MODE_B = DATA_W - 1;

    logic [SEL_W-1:0]  sel;
    logic [CODE_W-1:0] region_code [REGIONS];
    logic [CODE_W-1:0] io_code;

    // region index comes from the top bits of the I/O offset
    assign sel = io_addr[IO_ADDR_W-1 -: SEL_W];

    for (genvar r = 0; r < REGIONS; r++) begin : g_region
        assign region_code[r] = (sel == SEL_W'(r)) ? ctrl[r*CODE_W +: CODE_W] : '0;
    end

    always_comb begin
        io_code = '0;
        for (int r = 0; r < REGIONS; r++) begin
            io_code = io_code | region_code[r];
        end
    end

    assign code = space ? ctrl[DM_LSB +: CODE_W] : io_code;
    assign mode = ctrl[MODE_B];
endmodule

// File: rtl/wsg_wait_calc.sv
module wsg_wait_calc #(
    parameter int unsigned CODE_W = wsg_pkg::WSG_CODE_W,
    localparam int unsigned CNT_W = CODE_W + 1
) (
    input  logic [CODE_W-1:0] code,
    input  logic              mode,
    output logic [CNT_W-1:0]  waits
);
    always_comb begin
        if (!mode) begin
            waits = {1'b0, code};
        end else if (code == '0) begin
            waits = '0;
        end else begin
            waits = {code, 1'b1};
        end
    end
endmodule

// File: rtl/wsg_wait_counter.sv
module wsg_wait_counter #(
    parameter int unsigned CNT_W = wsg_pkg::WSG_CODE_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic [CNT_W-1:0] load_val,
    output logic             ready,
    output logic             done
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             done;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic       idle;

    assign idle = (st_q.cnt == '0);

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (idle) begin
            if (req) begin
                st_d.cnt  = load_val;
                st_d.done = (load_val == '0);
            end
        end else begin
            st_d.cnt  = st_q.cnt - 1'b1;
            st_d.done = (st_q.cnt == CNT_W'(1));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt  <= '0;
            st_q.done <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ready = idle;
    assign done  = st_q.done;
endmodule

// File: rtl/wait_state_gen.sv
module wait_state_gen #(
    parameter int unsigned ADDR_W    = wsg_pkg::WSG_ADDR_W,
    parameter int unsigned DATA_W    = wsg_pkg::WSG_DATA_W,
    parameter int unsigned CODE_W    = wsg_pkg::WSG_CODE_W,
    parameter int unsigned REGIONS   = wsg_pkg::WSG_REGIONS,
    parameter int unsigned IO_ADDR_W = wsg_pkg::WSG_IO_ADDR_W,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = wsg_pkg::WSG_CTRL_ADDR
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_value,
    input  logic              req_valid,
    input  logic              req_space,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              xfer_ready,
    output logic              xfer_done
);
    localparam int unsigned CNT_W = CODE_W + 1;

    logic [DATA_W-1:0] ctrl_word;
    logic [CODE_W-1:0] sel_code;
    logic              mode_bit;
    logic [CNT_W-1:0]  wait_val;

    wsg_ctrl_reg #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_ADDR(CTRL_ADDR)
    ) u_reg (
        .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en),
        .wr_addr(cfg_addr), .wr_data(cfg_wdata), .value(ctrl_word)
    );

    wsg_region_decode #(
        .DATA_W(DATA_W), .CODE_W(CODE_W), .REGIONS(REGIONS), .IO_ADDR_W(IO_ADDR_W)
    ) u_dec (
        .io_addr(req_addr[IO_ADDR_W-1:0]), .space(req_space),
        .ctrl(ctrl_word), .code(sel_code), .mode(mode_bit)
    );

    wsg_wait_calc #(.CODE_W(CODE_W)) u_calc (
        .code(sel_code), .mode(mode_bit), .waits(wait_val)
    );

    wsg_wait_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .req(req_valid), .load_val(wait_val),
        .ready(xfer_ready), .done(xfer_done)
    );

    assign cfg_value = ctrl_word;
endmodule

// File: rtl/wsg_checker.sv
module wsg_checker #(
    parameter int unsigned ADDR_W = 14,
    parameter int unsigned DATA_W = 16,
    parameter int unsigned CNT_W  = 4,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 14'h3FFE
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_wr_en,
    input logic [ADDR_W-1:0] cfg_addr,
    input logic [DATA_W-1:0] cfg_wdata,
    input logic [DATA_W-1:0] cfg_value,
    input logic              req_valid,
    input logic              xfer_ready,
    input logic              xfer_done,
    input logic              mode_bit,
    input logic [CNT_W-1:0]  wait_val
);
    AST_CFG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_en && cfg_addr == CTRL_ADDR) |=> (cfg_value == $past(cfg_wdata))); // R2
    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_wr_en) |=> $stable(cfg_value)); // R2
    AST_SINGLE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_bit) |-> (wait_val <= CNT_W'(7))); // R5
    AST_DOUBLE_ODD: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_bit && wait_val != '0) |-> wait_val[0]); // R6
    AST_DONE_READY: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |-> xfer_ready); // R8
    AST_ZERO_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && xfer_ready && wait_val == '0) |=> xfer_done); // R8
    AST_BUSY_FROM_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(xfer_ready) |-> $past(req_valid)); // R9
    AST_NO_DONE_MIDWAY: assert property (@(posedge clk) disable iff (!rst_n)
        (!xfer_ready) |=> (!xfer_done || xfer_ready)); // R8
endmodule

bind wait_state_gen wsg_checker #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CODE_W + 1), .CTRL_ADDR(CTRL_ADDR)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_value(cfg_value), .req_valid(req_valid),
    .xfer_ready(xfer_ready), .xfer_done(xfer_done), .mode_bit(mode_bit),
    .wait_val(wait_val)
);

// File: tb/sim_wait_state_gen.sv
module sim_wait_state_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [13:0] cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_value;
    logic        req_valid = 1'b0;
    logic        req_space = 1'b0;
    logic [13:0] req_addr = '0;
    logic        xfer_ready;
    logic        xfer_done;

    int n_checks = 0;
    int n_fail   = 0;
    logic [15:0] cfg_model = 16'hFFFF;

    always #10 clk = ~clk;

    wait_state_gen u0 (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_value(cfg_value), .req_valid(req_valid),
        .req_space(req_space), .req_addr(req_addr),
        .xfer_ready(xfer_ready), .xfer_done(xfer_done)
    );

    function automatic int exp_waits(input logic [15:0] cfg, input logic sp,
                                     input logic [13:0] addr);
        int code;
        if (sp) code = int'(cfg[14:12]);
        else    code = int'(cfg[3*int'(addr[10:9]) +: 3]);
        if (!cfg[15]) return code;
        if (code == 0) return 0;
        return 2*code + 1;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr_cfg(input logic [13:0] a, input logic [15:0] d);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr_en = 1'b0;
        if (a == 14'h3FFE) cfg_model = d;
    endtask

    // inj: 0 none, 1 extra request while busy, 2 control write while busy
    task automatic access(input logic sp, input logic [13:0] a, input int inj,
                          input string tag);
        int exp;
        int cnt;
        exp = exp_waits(cfg_model, sp, a);
        @(negedge clk);
        req_valid = 1'b1; req_space = sp; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        cnt = 0;
        while (!xfer_done && cnt < 40) begin
            chk(!xfer_ready, tag, int'(xfer_ready), 0);
            cnt++;
            if (cnt == 1 && inj == 1) begin
                req_valid = 1'b1; req_space = ~sp; req_addr = a ^ 14'h0600;
            end else if (cnt == 1 && inj == 2) begin
                cfg_wr_en = 1'b1; cfg_addr = 14'h3FFE; cfg_wdata = 16'h0000;
            end else begin
                req_valid = 1'b0; cfg_wr_en = 1'b0;
            end
            @(negedge clk);
        end
        req_valid = 1'b0; cfg_wr_en = 1'b0;
        if (inj == 2 && exp > 0) cfg_model = 16'h0000;
        chk(cnt == exp, tag, cnt, exp);
        chk(xfer_done && xfer_ready, tag, int'({xfer_done, xfer_ready}), 3);
        @(negedge clk);
        chk(!xfer_done && xfer_ready, tag, int'({xfer_done, xfer_ready}), 1);
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL R8 watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(cfg_value == 16'hFFFF, "R1", int'(cfg_value), 16'hFFFF);
        chk(xfer_ready == 1'b1, "R1", int'(xfer_ready), 1);
        chk(xfer_done == 1'b0, "R1", int'(xfer_done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R6 reset config: code 7 doubled -> 15
        access(1'b0, 14'h0123, 0, "R6");
        access(1'b1, 14'h0456, 0, "R7");
        // R2 write and ignored write
        wr_cfg(14'h3FFE, 16'h0000);
        chk(cfg_value == 16'h0000, "R2", int'(cfg_value), 0);
        wr_cfg(14'h3FFD, 16'h1234);
        chk(cfg_value == 16'h0000, "R2", int'(cfg_value), 0);
        // R8 zero-wait
        access(1'b0, 14'h0000, 0, "R8");
        access(1'b1, 14'h0000, 0, "R8");
        // R3 R4 R5 layout and region decode
        wr_cfg(14'h3FFE, 16'h58D1);
        chk(cfg_value == 16'h58D1, "R3", int'(cfg_value), 16'h58D1);
        access(1'b0, 14'h0000, 0, "R3");
        access(1'b0, 14'h0200, 0, "R3");
        access(1'b0, 14'h05FF, 0, "R5");
        access(1'b0, 14'h0600, 0, "R4");
        access(1'b0, 14'h3A00, 0, "R4");
        access(1'b0, 14'h3FFF, 0, "R4");
        access(1'b1, 14'h0600, 0, "R7");
        // R6 code 0 in doubled mode, code 7 doubled
        wr_cfg(14'h3FFE, 16'h8E38);
        access(1'b0, 14'h0000, 0, "R6");
        access(1'b0, 14'h0200, 0, "R6");
        access(1'b0, 14'h0600, 0, "R6");
        access(1'b1, 14'h0000, 0, "R7");
        // R9 busy ignores request and control change
        wr_cfg(14'h3FFE, 16'hFFFF);
        access(1'b0, 14'h0100, 1, "R9");
        access(1'b1, 14'h0100, 2, "R9");
        chk(cfg_value == 16'h0000, "R2", int'(cfg_value), 0);
        // random mix
        for (int i = 0; i < 400; i++) begin
            if (i % 8 == 0) wr_cfg(14'h3FFE, 16'($urandom));
            access(1'($urandom), 14'($urandom), int'($urandom % 3), "R8");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule